// File: doc/BRIEF.md
# E1 Timeslot-16 Signalling Multiframe Assembler

This block produces the timeslot-16 octet of an E1 transmit frame for each of the sixteen frames of a signalling multiframe. A frame counter runs through the multiframe, stepping once on each frame strobe. In frames 1 to 15 the octet carries two four-bit ABCD signalling nibbles, one for each of two voice channels. Frame 0 carries the multiframe alignment word with the spare and alarm bits.

Each of the 30 voice channels has its own source select bit. A select register holds these bits, and a load strobe writes the register. A clear bit takes that channel's nibble from the backplane signalling stream. A set bit takes it from the channel's signalling data register.

Voice channels are numbered 1 to 30. Timeslots 1 to 15 carry channels 1 to 15. Timeslots 17 to 31 carry channels 16 to 30, because timeslot 16 is skipped. The octet is registered, so it appears one clock after the counter value and the inputs it was built from.

Top module: `cas_mf_assembler`

## Requirements
- R1: `frame_num` is 0 after reset. It increments by one on each clock with `frame_stb` high and wraps from 15 to 0. Without the strobe it holds its value.
- R2: When `frame_num` is 0, the next `ts16_octet` has bits [7:4] = 4'b0000 and bits [3:0] equal to `spare_bits`.
- R3: When `frame_num` is k (1..15), the next `ts16_octet` bits [7:4] carry the nibble of channel k (timeslot k). Bit 7 is the first transmitted bit.
- R4: When `frame_num` is k (1..15), the next `ts16_octet` bits [3:0] carry the nibble of channel k+15 (timeslot k+16).
- R5: The nibble of channel c uses select bit `sel_in[c-1]` as last loaded. 0 takes `bp_nibbles[4c-1:4c-4]`. 1 takes `reg_nibbles[4c-1:4c-4]`.
- R6: All select bits are 0 after reset. They change only on a clock with `sel_load` high, and take `sel_in` there. The new value first affects the octet built on the following clock.
- R7: `ts16_octet` is 0 during reset. After reset it is built from the `frame_num`, select state and nibble inputs present at the previous clock edge.
- R8: The select bit of one channel has no effect on the nibble of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | Advances the multiframe frame counter |
| sel_load | input | 1 | Writes `sel_in` into the select register |
| sel_in | input | 30 | Per-channel source select, bit c-1 for channel c |
| reg_nibbles | input | 120 | Register signalling nibbles, channel c at [4c-1:4c-4] |
| bp_nibbles | input | 120 | Backplane signalling nibbles, channel c at [4c-1:4c-4] |
| spare_bits | input | 4 | Spare/alarm bits sent in frame 0 |
| frame_num | output | 4 | Current frame within the multiframe |
| ts16_octet | output | 8 | Timeslot-16 octet, bit 7 transmitted first |

## Verification
The source-select assertions assume that the nibble and select inputs are stable from one clock edge until the comparison in the next cycle. They also assume that `frame_stb` is a single-cycle event relative to the counter. The bench changes every input only on the falling clock edge, so each value is held across the rising edge that samples it. Select loads, strobes and nibble values come from seeded random patterns and are mixed with fixed patterns: all backplane, all register and alternating selects.

// File: rtl/cas_pkg.sv
package cas_pkg;
    localparam int CAS_CH_N   = 30;
    localparam int CAS_NIB_W  = 4;
    localparam int CAS_FRAMES = 16;
    localparam int CAS_FRM_W  = $clog2(CAS_FRAMES);
    localparam int CAS_OCT_W  = 2 * CAS_NIB_W;
endpackage

// File: rtl/cas_frame_ctr.sv
module cas_frame_ctr #(
    parameter int FRAMES = cas_pkg::CAS_FRAMES,
    localparam int FW    = $clog2(FRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    output logic [FW-1:0] frm_q
);
    typedef struct packed {
        logic [FW-1:0] frm;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stb) begin
            if (st_q.frm == FW'(FRAMES - 1)) st_d.frm = '0;
            else                             st_d.frm = st_q.frm + FW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frm_q = st_q.frm;

    // R1
    frm_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && frm_q == FW'(FRAMES - 1)) |=> (frm_q == '0));
    // R1
    frm_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && frm_q != FW'(FRAMES - 1)) |=> (frm_q == $past(frm_q) + FW'(1)));
    // R1
    frm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(frm_q));
endmodule

// File: rtl/cas_sel_reg.sv
module cas_sel_reg #(
    parameter int CH_N = cas_pkg::CAS_CH_N
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [CH_N-1:0] wdata,
    output logic [CH_N-1:0] sel_q
);
    typedef struct packed {
        logic [CH_N-1:0] sel;
    } sel_st_t;

    sel_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) st_d.sel = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_q = st_q.sel;

    // R6
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(sel_q));
    // R6
    sel_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sel_q == $past(wdata)));
endmodule

// File: rtl/cas_src_mux.sv
module cas_src_mux #(
    parameter int CH_N  = cas_pkg::CAS_CH_N,
    parameter int NIB_W = cas_pkg::CAS_NIB_W,
    localparam int VW   = CH_N * NIB_W
) (
    input  logic [CH_N-1:0] sel,
    input  logic [VW-1:0]   reg_nib,
    input  logic [VW-1:0]   bp_nib,
    output logic [VW-1:0]   pick
);
    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        logic [NIB_W-1:0] nib_d;
        always_comb begin
            if (sel[c]) nib_d = reg_nib[c*NIB_W +: NIB_W];
            else        nib_d = bp_nib[c*NIB_W +: NIB_W];
        end
        assign pick[c*NIB_W +: NIB_W] = nib_d;
    end
endmodule

// File: rtl/cas_octet_build.sv
module cas_octet_build #(
    parameter int CH_N   = cas_pkg::CAS_CH_N,
    parameter int NIB_W  = cas_pkg::CAS_NIB_W,
    parameter int FRAMES = cas_pkg::CAS_FRAMES,
    localparam int FW    = $clog2(FRAMES),
    localparam int VW    = CH_N * NIB_W,
    localparam int OW    = 2 * NIB_W,
    localparam int HALF  = CH_N / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FW-1:0]    frm,
    input  logic [VW-1:0]    pick,
    input  logic [NIB_W-1:0] spare,
    output logic [OW-1:0]    octet_q
);
    typedef struct packed {
        logic [OW-1:0] oct;
    } oct_st_t;

    oct_st_t st_d, st_q;

    always_comb begin
        st_d.oct = {{NIB_W{1'b0}}, spare};
        for (int f = 1; f < FRAMES; f++) begin
            if (frm == FW'(f)) begin
                st_d.oct = {pick[(f-1)*NIB_W +: NIB_W],
                            pick[(f-1+HALF)*NIB_W +: NIB_W]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign octet_q = st_q.oct;

    // R2
    mf_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm == '0) |=> (octet_q[OW-1:NIB_W] == '0));
    // R2
    mf_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm == '0) |=> (octet_q[NIB_W-1:0] == $past(spare)));
endmodule

// File: rtl/cas_mf_assembler.sv
module cas_mf_assembler #(
    parameter int CH_N   = cas_pkg::CAS_CH_N,
    parameter int NIB_W  = cas_pkg::CAS_NIB_W,
    parameter int FRAMES = cas_pkg::CAS_FRAMES,
    localparam int FW    = $clog2(FRAMES),
    localparam int VW    = CH_N * NIB_W,
    localparam int OW    = 2 * NIB_W,
    localparam int HALF  = CH_N / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic             sel_load,
    input  logic [CH_N-1:0]  sel_in,
    input  logic [VW-1:0]    reg_nibbles,
    input  logic [VW-1:0]    bp_nibbles,
    input  logic [NIB_W-1:0] spare_bits,
    output logic [FW-1:0]    frame_num,
    output logic [OW-1:0]    ts16_octet
);
    logic [FW-1:0]   frm_q;
    logic [CH_N-1:0] sel_q;
    logic [VW-1:0]   pick;

    cas_frame_ctr #(.FRAMES(FRAMES)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (frame_stb),
        .frm_q (frm_q)
    );

    cas_sel_reg #(.CH_N(CH_N)) u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sel_load),
        .wdata (sel_in),
        .sel_q (sel_q)
    );

    cas_src_mux #(.CH_N(CH_N), .NIB_W(NIB_W)) u_mux (
        .sel     (sel_q),
        .reg_nib (reg_nibbles),
        .bp_nib  (bp_nibbles),
        .pick    (pick)
    );

    cas_octet_build #(.CH_N(CH_N), .NIB_W(NIB_W), .FRAMES(FRAMES)) u_oct (
        .clk     (clk),
        .rst_n   (rst_n),
        .frm     (frm_q),
        .pick    (pick),
        .spare   (spare_bits),
        .octet_q (ts16_octet)
    );

    assign frame_num = frm_q;

    // Checker view: the raw inputs that belong to the current frame's two channels
    logic             hi_sel, lo_sel;
    logic [NIB_W-1:0] hi_reg, hi_bp, lo_reg, lo_bp;
    always_comb begin
        hi_sel = 1'b0; lo_sel = 1'b0;
        hi_reg = '0; hi_bp = '0; lo_reg = '0; lo_bp = '0;
        for (int f = 1; f < FRAMES; f++) begin
            if (frm_q == FW'(f)) begin
                hi_sel = sel_q[f-1];
                lo_sel = sel_q[f-1+HALF];
                hi_reg = reg_nibbles[(f-1)*NIB_W +: NIB_W];
                hi_bp  = bp_nibbles[(f-1)*NIB_W +: NIB_W];
                lo_reg = reg_nibbles[(f-1+HALF)*NIB_W +: NIB_W];
                lo_bp  = bp_nibbles[(f-1+HALF)*NIB_W +: NIB_W];
            end
        end
    end

    // R3 R5
    hi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_q != '0) |=> (ts16_octet[OW-1:NIB_W] == ($past(hi_sel) ? $past(hi_reg) : $past(hi_bp))));
    // R4 R5
    lo_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_q != '0) |=> (ts16_octet[NIB_W-1:0] == ($past(lo_sel) ? $past(lo_reg) : $past(lo_bp))));
endmodule

// File: tb/tb_cas_mf_assembler.sv
module tb_cas_mf_assembler;
    localparam int CLK_P = 10;
    localparam int CH    = 30;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           frame_stb = 1'b0;
    logic           sel_load = 1'b0;
    logic [CH-1:0]  sel_in = '0;
    logic [119:0]   reg_nibbles = '0;
    logic [119:0]   bp_nibbles = '0;
    logic [3:0]     spare_bits = '0;
    logic [3:0]     frame_num;
    logic [7:0]     ts16_octet;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_P/2) clk = ~clk;

    cas_mf_assembler dut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .sel_load(sel_load),
        .sel_in(sel_in), .reg_nibbles(reg_nibbles), .bp_nibbles(bp_nibbles),
        .spare_bits(spare_bits), .frame_num(frame_num), .ts16_octet(ts16_octet)
    );

    // Behavioural reference
    int m_frame = 0;
    int m_sel[CH];
    int e_frame = 0;
    int e_oct   = 0;
    int e_frm_src = 0;  // frame the expected octet was built for

    function automatic int nib_of(logic [119:0] v, int ch);
        return int'((v >> (4*(ch-1))) & 120'hF);
    endfunction

    function automatic int chan_nib(int ch);
        return (m_sel[ch-1] != 0) ? nib_of(reg_nibbles, ch) : nib_of(bp_nibbles, ch);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_frame = 0;
            foreach (m_sel[i]) m_sel[i] = 0;
            e_oct = 0; e_frame = 0; e_frm_src = -1;
        end else begin
            e_frm_src = m_frame;
            if (m_frame == 0) e_oct = int'(spare_bits);
            else e_oct = (chan_nib(m_frame) << 4) | chan_nib(m_frame + 15);
            if (sel_load) foreach (m_sel[i]) m_sel[i] = int'(sel_in[i]);
            if (frame_stb) m_frame = (m_frame + 1) % 16;
            e_frame = m_frame;
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every clock, a quarter period after the rising edge
    always @(posedge clk) begin
        #(CLK_P/4);
        if (rst_n && !done) begin
            check("R1 frame_num", int'(frame_num), e_frame);
            if (e_frm_src == 0)
                check("R2 frame0 octet", int'(ts16_octet), e_oct);
            else if (e_frm_src > 0) begin
                check("R3 R5 R8 first nibble", int'(ts16_octet[7:4]), (e_oct >> 4) & 15);
                check("R4 R5 R8 second nibble", int'(ts16_octet[3:0]), e_oct & 15);
            end
        end
    end

    task automatic run(int n, int stb_pct, bit rnd_nib);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_stb = ($urandom % 100) < stb_pct;
            sel_load = 1'b0;
            if (rnd_nib) begin
                reg_nibbles = {$urandom, $urandom, $urandom, $urandom};
                bp_nibbles  = {$urandom, $urandom, $urandom, $urandom};
                spare_bits  = 4'($urandom);
            end
        end
    endtask

    task automatic load_sel(logic [CH-1:0] v);
        @(negedge clk);
        sel_load = 1'b1; sel_in = v; frame_stb = 1'b0;
        @(negedge clk);
        sel_load = 1'b0; sel_in = ~v;  // later changes must not matter (R6)
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7: octet and counter cleared during reset
        check("R7 reset octet", int'(ts16_octet), 0);
        check("R1 reset frame", int'(frame_num), 0);
        reg_nibbles = {30{4'hA}};
        bp_nibbles  = {30{4'h5}};
        spare_bits  = 4'hB;
        rst_n = 1'b1;
        // R6: selects reset to zero, so every nibble comes from the backplane
        run(40, 100, 1'b0);
        run(200, 60, 1'b1);
        load_sel({CH{1'b1}});            // R5 all register
        run(200, 70, 1'b1);
        load_sel({15{2'b01}});           // R8 alternating channels
        run(200, 100, 1'b1);
        for (int k = 0; k < 20; k++) begin
            load_sel(CH'({$urandom, $urandom}));
            run(50, 50, 1'b1);
        end
        // Mid-run reset returns to frame 0 and backplane source
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R7 reset octet again", int'(ts16_octet), 0);
        check("R1 reset frame again", int'(frame_num), 0);
        rst_n = 1'b1;
        run(100, 80, 1'b1);              // R6 selects are zero again
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule